// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave side of an SPI bus in front of a 32K x 8 byte-addressed memory. It runs on a system clock much faster than the serial clock. The serial clock, select, data-in and pause inputs pass through two-flop synchronisers, and edge detectors turn them into single-cycle events. On each rising serial clock edge it shifts in one bit, MSB first. First comes an 8-bit opcode, and then, for memory accesses, a 16-bit address frame. Six instructions are decoded.

Reads stream bytes out of an internal array model. The address increments after every byte and wraps from the top of the space to zero. A status read streams the status byte, which the protection logic supplies. Write data bytes and status-write bytes are not stored here: each is passed out as a one-cycle pulse with its address and data. A separate commit pulse is raised only when select goes high exactly on a byte boundary, and the downstream commit and protection logic acts on that pulse. The pause input freezes the serial sequence in place, so that transfer can resume later from the same bit.

Top module: `sermem_cmd_front`

## Requirements
- R1: Opcode byte 0x06 gives one `wel_set_o` pulse and 0x04 gives one `wel_clr_o` pulse. 0x05 is status read, 0x01 is status write, 0x03 is memory read and 0x02 is memory write.
- R2: SI is taken on the rising SCK edge and SO changes only after the falling SCK edge. This holds both with SCK idling low (mode 0) and with SCK idling high (mode 3).
- R3: A memory read takes a 16-bit address frame MSB first and ignores its top bit. Each byte sent is `A[7:0] ^ {1'b0, A[14:8]} ^ 8'h5A` for the current 15-bit address A, MSB first.
- R4: During a read the address advances by one after each byte, wrapping from 0x7FFF to 0x0000, for as long as select stays low.
- R5: With select high, `so_oe_o` is low and the sequence is abandoned. The next select starts again with a fresh opcode.
- R6: After reset, no instruction is accepted until select has been seen high and then low.
- R7: While the pause input is low, SCK edges are ignored, SO holds its value and `so_oe_o` is low. After release, the transfer continues from the bit where it stopped.
- R8: A status read shifts out `status_i` right after the opcode. It samples `status_i` again at the start of each further byte.
- R9: In a memory write, each complete data byte gives a `wr_byte_vld_o` pulse carrying its address and data. The low 6 address bits wrap inside the 64-byte page.
- R10: `wr_commit_o` pulses when select rises exactly on a byte boundary after at least one data byte. It does not pulse if select rises at any other point.
- R11: A status write gives a `sr_byte_vld_o` pulse with the 8 data bits. `sr_commit_o` pulses only if select rises right after the eighth data bit.
- R12: An unknown opcode makes the block ignore every later bit until select goes high. No pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| status_i | input | 8 | Status byte from protection logic |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO |
| wel_set_o | output | 1 | Write-enable set request pulse |
| wel_clr_o | output | 1 | Write-enable clear request pulse |
| wr_byte_vld_o | output | 1 | Write data byte valid pulse |
| wr_addr_o | output | 15 | Address of the write byte |
| wr_data_o | output | 8 | Write data byte |
| wr_commit_o | output | 1 | Memory write commit pulse |
| sr_byte_vld_o | output | 1 | Status write byte valid pulse |
| sr_data_o | output | 8 | Status write data |
| sr_commit_o | output | 1 | Status write commit pulse |

## Verification
The hardest case to reach is a pause in the middle of a frame. The pause must begin and end while SCK is low, and the serial clock must keep toggling while paused. This must happen once inside the address frame and once inside a data byte being read. The stimulus lowers the pause input half a serial period after a falling SCK edge, toggles SCK with junk on SI, and releases the pause before the next bit. The data byte read afterwards must match the byte for the intended address. A second hard case is the power-up condition: select is held low through reset, and the bench shows that a whole opcode clocked in at that point produces nothing.

// File: rtl/smf_pkg.sv
`timescale 1ns/1ps
package smf_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPC,
    S_ADDR,
    S_RD,
    S_WR,
    S_RDSR,
    S_WRSR,
    S_SRDONE,
    S_SKIP
  } seq_state_e;
endpackage

// File: rtl/smf_sync.sv
`timescale 1ns/1ps
module smf_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/smf_array_model.sv
`timescale 1ns/1ps
module smf_array_model #(
  parameter int         ADDR_W = 15,
  parameter logic [7:0] SEED   = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        data_o
);
  // Computed pattern stands in for the stored array
  assign data_o = addr_i[7:0] ^ 8'(addr_i[ADDR_W-1:8]) ^ SEED;
endmodule

// File: rtl/smf_seq.sv
`timescale 1ns/1ps
module smf_seq
  import smf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              si_i,
  input  logic              held_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              wr_byte_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              sr_byte_vld_o,
  output logic [7:0]        sr_data_o,
  output logic              sr_commit_o
);
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(FRAME_W-1);

  seq_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;
  logic [ADDR_W-1:0] sh_nx;
  logic [ADDR_W-1:0] addr;
  logic              is_rd;
  logic              wr_any;
  logic [7:0]        obyte;
  logic [7:0]        src;
  logic              so_q;
  logic              adv_r;
  logic              adv_f;

  assign sh_nx = {sh[ADDR_W-2:0], si_i};
  assign adv_r = sck_rise_i & ~held_i & (st != S_IDLE);
  assign adv_f = sck_fall_i & ~held_i & (st != S_IDLE);
  assign src   = (st == S_RD) ? rd_data_i : status_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st            <= S_IDLE;
      cnt           <= '0;
      sh            <= '0;
      addr          <= '0;
      is_rd         <= 1'b0;
      wr_any        <= 1'b0;
      obyte         <= '0;
      so_q          <= 1'b0;
      wel_set_o     <= 1'b0;
      wel_clr_o     <= 1'b0;
      wr_byte_vld_o <= 1'b0;
      wr_addr_o     <= '0;
      wr_data_o     <= '0;
      wr_commit_o   <= 1'b0;
      sr_byte_vld_o <= 1'b0;
      sr_data_o     <= '0;
      sr_commit_o   <= 1'b0;
    end else begin
      wel_set_o     <= 1'b0;
      wel_clr_o     <= 1'b0;
      wr_byte_vld_o <= 1'b0;
      wr_commit_o   <= 1'b0;
      sr_byte_vld_o <= 1'b0;
      sr_commit_o   <= 1'b0;
      if (cs_rise_i) begin
        // Commit only on an exact byte boundary
        wr_commit_o <= (st == S_WR) && (cnt == '0) && wr_any;
        sr_commit_o <= (st == S_SRDONE);
        st          <= S_IDLE;
      end else if (cs_fall_i) begin
        st     <= S_OPC;
        cnt    <= '0;
        wr_any <= 1'b0;
      end else if (adv_r) begin
        sh  <= sh_nx;
        cnt <= cnt + CNT_W'(1);
        unique case (st)
          S_OPC: begin
            if (cnt == LAST_BIT) begin
              cnt <= '0;
              unique case (sh_nx[7:0])
                OP_WREN:  begin wel_set_o <= 1'b1; st <= S_SKIP; end
                OP_WRDI:  begin wel_clr_o <= 1'b1; st <= S_SKIP; end
                OP_RDSR:  st <= S_RDSR;
                OP_WRSR:  st <= S_WRSR;
                OP_READ:  begin is_rd <= 1'b1; st <= S_ADDR; end
                OP_WRITE: begin is_rd <= 1'b0; st <= S_ADDR; end
                default:  st <= S_SKIP;
              endcase
            end
          end
          S_ADDR: begin
            if (cnt == LAST_ADDR) begin
              cnt  <= '0;
              addr <= sh_nx;
              st   <= is_rd ? S_RD : S_WR;
            end
          end
          S_RD: begin
            if (cnt == LAST_BIT) begin
              cnt  <= '0;
              addr <= addr + ADDR_W'(1);
            end
          end
          S_RDSR: begin
            if (cnt == LAST_BIT) cnt <= '0;
          end
          S_WR: begin
            if (cnt == LAST_BIT) begin
              cnt           <= '0;
              wr_byte_vld_o <= 1'b1;
              wr_addr_o     <= addr;
              wr_data_o     <= sh_nx[7:0];
              addr          <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
              wr_any        <= 1'b1;
            end
          end
          S_WRSR: begin
            if (cnt == LAST_BIT) begin
              sr_byte_vld_o <= 1'b1;
              sr_data_o     <= sh_nx[7:0];
              st            <= S_SRDONE;
            end
          end
          S_SRDONE: st <= S_SKIP;
          default: ;
        endcase
      end else if (adv_f) begin
        if (st == S_RD || st == S_RDSR) begin
          if (cnt == '0) begin
            obyte <= src;
            so_q  <= src[7];
          end else begin
            so_q  <= obyte[~cnt[2:0]];
          end
        end
      end
    end
  end

  assign rd_addr_o = addr;
  assign so_o      = so_q;
  assign so_oe_o   = (st != S_IDLE) & ~cs_s_i & ~held_i;
endmodule

// File: rtl/sermem_cmd_front.sv
`timescale 1ns/1ps
module sermem_cmd_front #(
  parameter int         ADDR_W      = 15,
  parameter int         PAGE_W      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MODEL_SEED  = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  input  logic [7:0]        status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic              wel_set_o,
  output logic              wel_clr_o,
  output logic              wr_byte_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              sr_byte_vld_o,
  output logic [7:0]        sr_data_o,
  output logic              sr_commit_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0]  raw;
  logic [NSYNC-1:0]  syn;
  logic              sck_s, cs_s, si_s, held;
  logic              sck_q, cs_q;
  logic              sck_rise, sck_fall, cs_rise, cs_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  assign raw = {hold_ni, si_i, cs_ni, sck_i};

  // cs resets low so a real high-then-low is needed after reset
  smf_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign sck_s = syn[0];
  assign cs_s  = syn[1];
  assign si_s  = syn[2];
  assign held  = ~syn[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign cs_fall  = ~cs_s & cs_q;

  smf_array_model #(.ADDR_W(ADDR_W), .SEED(MODEL_SEED)) u_array (
    .addr_i(rd_addr),
    .data_o(rd_data)
  );

  smf_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_s_i       (cs_s),
    .cs_fall_i    (cs_fall),
    .cs_rise_i    (cs_rise),
    .sck_rise_i   (sck_rise),
    .sck_fall_i   (sck_fall),
    .si_i         (si_s),
    .held_i       (held),
    .status_i     (status_i),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .so_o         (so_o),
    .so_oe_o      (so_oe_o),
    .wel_set_o    (wel_set_o),
    .wel_clr_o    (wel_clr_o),
    .wr_byte_vld_o(wr_byte_vld_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .wr_commit_o  (wr_commit_o),
    .sr_byte_vld_o(sr_byte_vld_o),
    .sr_data_o    (sr_data_o),
    .sr_commit_o  (sr_commit_o)
  );
endmodule

// File: rtl/smf_checker.sv
`timescale 1ns/1ps
module smf_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s_i,
  input logic held_i,
  input logic so_i,
  input logic so_oe_i,
  input logic wel_set_i,
  input logic wel_clr_i,
  input logic wr_commit_i,
  input logic sr_commit_i
);
  a_r5_oe_off_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |-> !so_oe_i);

  a_r7_oe_off_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_i |-> !so_oe_i);

  a_r7_so_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_i && $past(held_i)) |-> $stable(so_i));

  a_r1_wel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wel_set_i && wel_clr_i));

  a_r10_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_i |=> !wr_commit_i);

  a_r11_sr_commit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_commit_i |=> !sr_commit_i);
endmodule

bind sermem_cmd_front smf_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s_i     (cs_s),
  .held_i     (held),
  .so_i       (so_o),
  .so_oe_i    (so_oe_o),
  .wel_set_i  (wel_set_o),
  .wel_clr_i  (wel_clr_o),
  .wr_commit_i(wr_commit_o),
  .sr_commit_i(sr_commit_o)
);

// File: tb/sermem_cmd_front_tb_top.sv
`timescale 1ns/1ps
module sermem_cmd_front_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;

  typedef struct packed {
    logic [15:0] a;
    logic        m3;
  } rd_vec_t;

  localparam rd_vec_t RD_TAB [6] = '{
    '{16'h0000, 1'b0},
    '{16'h1234, 1'b1},
    '{16'h8ABC, 1'b0},
    '{16'h7FFE, 1'b0},
    '{16'hFFFF, 1'b1},
    '{16'h00FF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b0;
  logic si = 1'b0;
  logic hold_n = 1'b1;
  logic [7:0] status = 8'h00;
  logic so, so_oe, wel_set, wel_clr, wr_vld, wr_cm, sr_vld, sr_cm;
  logic [14:0] wr_addr;
  logic [7:0] wr_data, sr_data;

  int n_chk = 0, n_fail = 0;
  int n_set = 0, n_clr = 0, n_wb = 0, n_wcm = 0, n_srv = 0, n_scm = 0;
  logic [14:0] wa [8];
  logic [7:0]  wd [8];
  logic [7:0]  last_sr;
  logic m3 = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sermem_cmd_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .status_i(status), .so_o(so), .so_oe_o(so_oe),
    .wel_set_o(wel_set), .wel_clr_o(wel_clr), .wr_byte_vld_o(wr_vld),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_cm),
    .sr_byte_vld_o(sr_vld), .sr_data_o(sr_data), .sr_commit_o(sr_cm)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (wel_set) n_set++;
      if (wel_clr) n_clr++;
      if (wr_cm)   n_wcm++;
      if (sr_cm)   n_scm++;
      if (sr_vld) begin n_srv++; last_sr = sr_data; end
      if (wr_vld) begin
        if (n_wb < 8) begin wa[n_wb] = wr_addr; wd[n_wb] = wr_data; end
        n_wb++;
      end
    end
  end

  function automatic logic [7:0] model(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic clr_cnt();
    n_set = 0; n_clr = 0; n_wb = 0; n_wcm = 0; n_srv = 0; n_scm = 0;
  endtask

  task automatic shift(input int n, input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      sck = 1'b0;
      si  = tx[7-i];
      #(HALF);
      rx  = {rx[6:0], so};
      sck = 1'b1;
      #(HALF);
      if (!m3) sck = 1'b0;
    end
  endtask

  task automatic sel();
    sck = m3;
    #(HALF);
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic desel();
    #(HALF);
    cs_n = 1'b1;
    #(4*HALF);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [7:0] rx;
    logic [7:0] r1, r2;
    logic so_hold;
    // Reset state with select held low from time zero
    #(5*CLK_P);
    rst_n = 1'b1;
    #(4*CLK_P);
    chk(so_oe, 0, "reset oe");
    chk(n_set, 0, "reset pulses");
    // R6: no select edge seen yet, opcode must be ignored
    shift(8, 8'h06, rx);
    #(HALF);
    chk(n_set, 0, "R6 no fall no decode");
    chk(so_oe, 0, "R6 oe stays low");
    cs_n = 1'b1;
    #(4*HALF);
    sel();
    shift(8, 8'h06, rx);
    desel();
    chk(n_set, 1, "R6 accepted after fall");

    // R2 R3 R4 read vector table
    foreach (RD_TAB[t]) begin
      m3 = RD_TAB[t].m3;
      sel();
      shift(8, 8'h03, rx);
      shift(8, RD_TAB[t].a[15:8], rx);
      shift(8, RD_TAB[t].a[7:0], rx);
      for (int k = 0; k < 3; k++) begin
        shift(8, 8'h00, rx);
        chk(rx, model(15'(RD_TAB[t].a[14:0] + 15'(k))), "R2 R3 R4 read byte");
      end
      desel();
    end
    m3 = 1'b0;
    sck = 1'b0;

    // R1 write-enable opcodes
    clr_cnt();
    sel(); shift(8, 8'h06, rx); desel();
    sel(); shift(8, 8'h04, rx); desel();
    chk(n_set, 1, "R1 set pulse");
    chk(n_clr, 1, "R1 clear pulse");

    // R8 status read, resampled per byte
    status = 8'hA6;
    sel();
    shift(8, 8'h05, rx);
    shift(8, 8'h00, rx);
    chk(rx, 8'hA6, "R8 status byte 0");
    status = 8'h3C;
    shift(8, 8'h00, rx);
    chk(rx, 8'h3C, "R8 status byte 1");
    desel();

    // R9 R10 page write with wrap and commit
    clr_cnt();
    sel();
    shift(8, 8'h02, rx);
    shift(8, 8'h81, rx);
    shift(8, 8'h3E, rx);
    shift(8, 8'h11, rx);
    shift(8, 8'h22, rx);
    shift(8, 8'h33, rx);
    shift(8, 8'h44, rx);
    desel();
    chk(n_wb, 4, "R9 byte count");
    chk(wa[0], 15'h013E, "R9 addr 0");
    chk(wa[1], 15'h013F, "R9 addr 1");
    chk(wa[2], 15'h0100, "R9 page wrap addr");
    chk(wa[3], 15'h0101, "R9 addr 3");
    chk(wd[2], 8'h33, "R9 data 2");
    chk(n_wcm, 1, "R10 commit on boundary");

    clr_cnt();
    sel();
    shift(8, 8'h02, rx);
    shift(8, 8'h00, rx);
    shift(8, 8'h10, rx);
    shift(8, 8'h5C, rx);
    shift(3, 8'hE0, rx);
    desel();
    chk(n_wb, 1, "R10 partial byte count");
    chk(n_wcm, 0, "R10 no commit off boundary");

    clr_cnt();
    sel();
    shift(8, 8'h02, rx);
    shift(8, 8'h00, rx);
    shift(8, 8'h10, rx);
    desel();
    chk(n_wcm, 0, "R10 no commit without data");

    // R11 status write
    clr_cnt();
    sel(); shift(8, 8'h01, rx); shift(8, 8'h8C, rx); desel();
    chk(n_srv, 1, "R11 sr byte pulse");
    chk(last_sr, 8'h8C, "R11 sr data");
    chk(n_scm, 1, "R11 sr commit");
    clr_cnt();
    sel(); shift(8, 8'h01, rx); shift(8, 8'h8C, rx); shift(1, 8'h80, rx); desel();
    chk(n_scm, 0, "R11 no commit on ninth bit");

    // R12 unknown opcode
    clr_cnt();
    sel();
    shift(8, 8'hFF, rx);
    shift(8, 8'h06, rx);
    shift(8, 8'h01, rx);
    shift(8, 8'h02, rx);
    desel();
    chk(n_set + n_clr + n_srv + n_wb, 0, "R12 no pulses after bad opcode");
    sel(); shift(8, 8'h06, rx); desel();
    chk(n_set, 1, "R12 recovers on next select");

    // R5 abandoned read, oe follows select
    clr_cnt();
    sel();
    chk(so_oe, 1, "R5 oe when selected");
    shift(8, 8'h03, rx);
    shift(5, 8'h00, rx);
    desel();
    chk(so_oe, 0, "R5 oe when deselected");
    sel(); shift(8, 8'h06, rx); desel();
    chk(n_set, 1, "R5 fresh opcode after abort");

    // R7 pause inside address frame
    sel();
    shift(8, 8'h03, rx);
    shift(8, 8'h00, rx);
    #(HALF);
    hold_n = 1'b0;
    #(HALF);
    chk(so_oe, 0, "R7 oe low while paused");
    for (int i = 0; i < 8; i++) begin
      si = i[0]; sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
    end
    hold_n = 1'b1;
    #(HALF);
    shift(8, 8'h40, rx);
    shift(8, 8'h00, rx);
    chk(rx, model(15'h0040), "R7 resume in address");
    // R7 pause inside data byte
    shift(4, 8'h00, r1);
    #(HALF);
    hold_n = 1'b0;
    #(HALF);
    so_hold = so;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
    end
    chk(so, so_hold, "R7 so frozen while paused");
    hold_n = 1'b1;
    #(HALF);
    shift(4, 8'h00, r2);
    chk({r1[3:0], r2[3:0]}, model(15'h0041), "R7 resume in data");
    desel();

    finish_up();
  end
endmodule